// File: doc/BRIEF.md
# Tuning Window Tap Selector

This block picks a sampling tap for a high-speed card interface once a tuning sweep has finished. The sweep probes each of N taps twice, in order, so it yields 2N entries. Entry i belongs to tap i mod N. Two bitmaps describe the sweep. The pass bitmap marks the probes that completed without error. The match bitmap marks the probes whose sampled data compared equal. A start strobe hands both bitmaps and the tap count to the block. The block then works through them serially, one bit per clock. When it finishes, it gives a one-cycle done pulse together with either a chosen tap (with automatic drift correction turned on) or a failure flag.

The work runs in three passes. The first pass is a merge: any failed probe marks both copies of its tap as failed, and this is applied to each bitmap separately. The second pass searches the merged pass bitmap for its longest run of set bits. If every entry passed, that search cannot tell taps apart, so the block searches the merged match bitmap instead. The chosen tap is the midpoint of the winning run, reduced modulo N. When tuning starts, a one-cycle drift-clear pulse tells the surrounding logic to discard any stale drift-correction requests.

The controller is a state machine with six states:
- IDLE waits for start.
- MERGE walks the 2N entries once.
- SCAN_PASS walks the merged pass bitmap.
- CHECK_PASS either decides, or goes on to SCAN_MATCH when the pass run covers all 2N entries.
- SCAN_MATCH walks the merged match bitmap.
- CHECK_MATCH decides and returns to IDLE.

An out-of-range tap count is decided directly from IDLE.

Top module: `tap_window_select`

## Requirements
- R1: After reset, done, fail, drift_en, drift_clr and tap_sel are all zero.
- R2: When a start is accepted in IDLE, drift_clr is high for exactly one cycle. In that same cycle drift_en and fail read zero.
- R3: Merge: if entry i of the pass bitmap is clear, the pass-bitmap entries for tap i mod N (that is, bits i mod N and i mod N + N) are both treated as failed. The match bitmap is merged the same way, using its own clear entries. Bits at index 2N and above are ignored.
- R4: The longest run of consecutive set bits in entries 0 to 2N-1 is found. A run that ends at entry 2N-1 also counts.
- R5: Among runs of equal length, the earliest one wins, because only a strictly longer run replaces the current best.
- R6: If the merged pass run covers all 2N entries, the decision uses the longest run of the merged match bitmap instead. The block selects a tap only if that run is non-zero.
- R7: Otherwise, the block selects a tap only if the longest pass run is at least 3 entries long.
- R8: The selected tap is ((run start + run end) / 2) mod N, using integer division.
- R9: If no tap is selected, fail is 1, drift_en is 0, and tap_sel keeps its previous value.
- R10: If a tap is selected, tap_sel is updated, drift_en is 1 and fail is 0.
- R11: done is a one-cycle pulse. A start that arrives while the block is busy is ignored.
- R12: A tap count of 0 or greater than 16 gives done and fail in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin selection using the values on the map and count inputs |
| tap_count | input | 8 | Number of taps N, sampled at start |
| pass_map | input | 32 | Per-entry probe success bitmap |
| match_map | input | 32 | Per-entry data-match bitmap |
| tap_sel | output | 4 | Selected sampling tap |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No usable tap was found |
| drift_en | output | 1 | Automatic drift correction enabled |
| drift_clr | output | 1 | One-cycle clear of pending drift requests |

## Verification
Several properties are checked by assertions on every cycle:
- done is never high for two cycles in a row.
- fail and drift_en are never high together.
- A successful selection always yields a tap below N.
- The merge only ever clears bits.
- The best run length never shrinks within one scan.
- A bad tap count produces done and fail in the next cycle.

Other behaviour can only be shown by the bench's scenarios, each run with chosen bitmaps and an expected tap:
- the duplicate-poisoning of the merge
- the earliest-run tie break
- the run that reaches the last entry
- the fallback to the match bitmap
- the minimum-length rule
- the midpoint arithmetic
- a held tap after a failed sweep
- a start ignored while busy

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MERGE,
        ST_SCAN_PASS,
        ST_CHECK_PASS,
        ST_SCAN_MATCH,
        ST_CHECK_MATCH
    } tws_state_e;

endpackage

// File: rtl/tws_merge.sv
`timescale 1ns/1ps
module tws_merge #(
    parameter int MAP_W = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             sel_match,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] tap_of_idx,
    input  logic [IDX_W-1:0] n_taps,
    input  logic [MAP_W-1:0] pass_in,
    input  logic [MAP_W-1:0] match_in,
    output logic             bit_out
);

    logic [MAP_W-1:0] pass_q, match_q;
    logic [MAP_W-1:0] pass_d, match_d;
    logic [IDX_W-1:0] twin;

    assign twin = tap_of_idx + n_taps;

    always_comb begin
        pass_d  = pass_q;
        match_d = match_q;
        if (!pass_q[idx]) begin
            pass_d[tap_of_idx] = 1'b0;
            pass_d[twin]       = 1'b0;
        end
        if (!match_q[idx]) begin
            match_d[tap_of_idx] = 1'b0;
            match_d[twin]       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q  <= '0;
            match_q <= '0;
        end else if (load) begin
            pass_q  <= pass_in;
            match_q <= match_in;
        end else if (step) begin
            pass_q  <= pass_d;
            match_q <= match_d;
        end
    end

    assign bit_out = sel_match ? match_q[idx] : pass_q[idx];

    // R3
    merge_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (((pass_q & ~$past(pass_q)) == '0) && ((match_q & ~$past(match_q)) == '0)));

endmodule

// File: rtl/tws_run_scan.sv
`timescale 1ns/1ps
module tws_run_scan #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    input  logic             last,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] best_cnt,
    output logic [IDX_W-1:0] best_start,
    output logic [IDX_W-1:0] best_end
);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] cand_cnt, cand_end, cand_start;
    logic             cand_take;

    always_comb begin
        cand_cnt   = bit_in ? run_q + CNT_W'(1) : run_q;
        cand_end   = bit_in ? CNT_W'(idx) : CNT_W'(idx) - CNT_W'(1);
        cand_start = cand_end + CNT_W'(1) - cand_cnt;
        cand_take  = (!bit_in || last) && (cand_cnt > best_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q      <= '0;
            best_cnt   <= '0;
            best_start <= '0;
            best_end   <= '0;
        end else if (step) begin
            run_q <= bit_in ? run_q + CNT_W'(1) : '0;
            if (cand_take) begin
                best_cnt   <= cand_cnt;
                best_start <= IDX_W'(cand_start);
                best_end   <= IDX_W'(cand_end);
            end
        end
    end

    // R5
    best_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_cnt >= $past(best_cnt));

    // R4
    run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> CNT_W'(best_end) >= CNT_W'(best_start) || best_cnt == '0);

endmodule

// File: rtl/tws_ctrl.sv
`timescale 1ns/1ps
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int MAX_TAPS = 16,
    parameter int CIN_W    = 8,
    parameter int MIN_RUN  = 3,
    parameter int IDX_W    = 5,
    parameter int CNT_W    = 6,
    parameter int NUM_W    = 5,
    parameter int TAP_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CIN_W-1:0] tap_count,
    input  logic [CNT_W-1:0] best_cnt,
    input  logic [IDX_W-1:0] best_start,
    input  logic [IDX_W-1:0] best_end,
    output logic             merge_load,
    output logic             merge_step,
    output logic             scan_clr,
    output logic             scan_step,
    output logic             scan_match,
    output logic             idx_last,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] tap_of_idx,
    output logic [IDX_W-1:0] n_taps,
    output logic [TAP_W-1:0] tap_sel,
    output logic             done,
    output logic             fail,
    output logic             drift_en,
    output logic             drift_clr
);

    tws_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, mod_q;
    logic [NUM_W-1:0] n_q;
    logic [CNT_W-1:0] two_n, mid, nn, tap_w;
    logic             count_bad, walking, pass_full, pick;

    assign count_bad = (tap_count == '0) || (tap_count > CIN_W'(MAX_TAPS));
    assign two_n     = CNT_W'(n_q) << 1;
    assign nn        = CNT_W'(n_q);
    assign idx_last  = (CNT_W'(idx_q) == two_n - CNT_W'(1));
    assign walking   = (state_q == ST_MERGE) || (state_q == ST_SCAN_PASS)
                    || (state_q == ST_SCAN_MATCH);
    assign pass_full = (best_cnt == two_n);
    assign mid       = (CNT_W'(best_start) + CNT_W'(best_end)) >> 1;
    assign tap_w     = (mid >= nn) ? mid - nn : mid;

    always_comb begin
        pick = 1'b0;
        if (state_q == ST_CHECK_PASS)
            pick = best_cnt >= CNT_W'(MIN_RUN);
        else if (state_q == ST_CHECK_MATCH)
            pick = best_cnt != '0;
    end

    assign merge_load = (state_q == ST_IDLE) && start && !count_bad;
    assign merge_step = (state_q == ST_MERGE);
    assign scan_step  = (state_q == ST_SCAN_PASS) || (state_q == ST_SCAN_MATCH);
    assign scan_match = (state_q == ST_SCAN_MATCH);
    assign scan_clr   = (state_q == ST_MERGE) || (state_q == ST_CHECK_PASS);
    assign idx        = idx_q;
    assign tap_of_idx = mod_q;
    assign n_taps     = IDX_W'(n_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start && !count_bad) state_d = ST_MERGE;
            ST_MERGE:       if (idx_last) state_d = ST_SCAN_PASS;
            ST_SCAN_PASS:   if (idx_last) state_d = ST_CHECK_PASS;
            ST_CHECK_PASS:  state_d = pass_full ? ST_SCAN_MATCH : ST_IDLE;
            ST_SCAN_MATCH:  if (idx_last) state_d = ST_CHECK_MATCH;
            ST_CHECK_MATCH: state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mod_q   <= '0;
            n_q     <= '0;
        end else begin
            state_q <= state_d;
            if (merge_load) begin
                idx_q <= '0;
                mod_q <= '0;
                n_q   <= NUM_W'(tap_count);
            end else if (walking) begin
                if (idx_last) begin
                    idx_q <= '0;
                    mod_q <= '0;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                    mod_q <= (mod_q == IDX_W'(n_q) - IDX_W'(1)) ? '0 : mod_q + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_sel   <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            drift_en  <= 1'b0;
            drift_clr <= 1'b0;
        end else begin
            done      <= 1'b0;
            drift_clr <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        drift_clr <= 1'b1;
                        drift_en  <= 1'b0;
                        fail      <= count_bad;
                        done      <= count_bad;
                    end
                end
                ST_CHECK_PASS, ST_CHECK_MATCH: begin
                    if (state_q == ST_CHECK_MATCH || !pass_full) begin
                        done <= 1'b1;
                        if (pick) begin
                            tap_sel  <= TAP_W'(tap_w);
                            drift_en <= 1'b1;
                            fail     <= 1'b0;
                        end else begin
                            drift_en <= 1'b0;
                            fail     <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !drift_en);

    // R8
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> CNT_W'(tap_sel) < CNT_W'(n_q));

    // R12
    bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && count_bad) |=> (done && fail));

    // R2
    drift_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drift_clr |-> (!drift_en && !$past(drift_clr)));

endmodule

// File: rtl/tap_window_select.sv
`timescale 1ns/1ps
module tap_window_select #(
    parameter int MAX_TAPS = 16,
    parameter int CIN_W    = 8,
    parameter int MIN_RUN  = 3,
    localparam int MAP_W   = 2 * MAX_TAPS,
    localparam int IDX_W   = $clog2(MAP_W),
    localparam int CNT_W   = IDX_W + 1,
    localparam int NUM_W   = $clog2(MAX_TAPS + 1),
    localparam int TAP_W   = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CIN_W-1:0] tap_count,
    input  logic [MAP_W-1:0] pass_map,
    input  logic [MAP_W-1:0] match_map,
    output logic [TAP_W-1:0] tap_sel,
    output logic             done,
    output logic             fail,
    output logic             drift_en,
    output logic             drift_clr
);

    logic             merge_load, merge_step, scan_clr, scan_step, scan_match;
    logic             idx_last, cur_bit;
    logic [IDX_W-1:0] idx, tap_of_idx, n_taps;
    logic [CNT_W-1:0] best_cnt;
    logic [IDX_W-1:0] best_start, best_end;

    tws_ctrl #(
        .MAX_TAPS(MAX_TAPS), .CIN_W(CIN_W), .MIN_RUN(MIN_RUN),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .NUM_W(NUM_W), .TAP_W(TAP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
        .best_cnt(best_cnt), .best_start(best_start), .best_end(best_end),
        .merge_load(merge_load), .merge_step(merge_step), .scan_clr(scan_clr),
        .scan_step(scan_step), .scan_match(scan_match), .idx_last(idx_last),
        .idx(idx), .tap_of_idx(tap_of_idx), .n_taps(n_taps),
        .tap_sel(tap_sel), .done(done), .fail(fail),
        .drift_en(drift_en), .drift_clr(drift_clr)
    );

    tws_merge #(.MAP_W(MAP_W), .IDX_W(IDX_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .load(merge_load), .step(merge_step),
        .sel_match(scan_match), .idx(idx), .tap_of_idx(tap_of_idx),
        .n_taps(n_taps), .pass_in(pass_map), .match_in(match_map),
        .bit_out(cur_bit)
    );

    tws_run_scan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .step(scan_step),
        .bit_in(cur_bit), .last(idx_last), .idx(idx),
        .best_cnt(best_cnt), .best_start(best_start), .best_end(best_end)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !fail && !drift_en && !drift_clr && tap_sel == '0));

endmodule

// File: tb/tap_window_select_test.sv
`timescale 1ns/1ps
module tap_window_select_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  tap_count = '0;
    logic [31:0] pass_map = '0;
    logic [31:0] match_map = '0;
    logic [3:0]  tap_sel;
    logic        done, fail, drift_en, drift_clr;

    int vectors = 0;
    int errs = 0;
    int cycles = 0;
    int last_tap = 0;

    always #2 clk = ~clk;

    tap_window_select uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
        .pass_map(pass_map), .match_map(match_map), .tap_sel(tap_sel),
        .done(done), .fail(fail), .drift_en(drift_en), .drift_clr(drift_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void longest(input logic [31:0] v, input int len,
                                    output int c, output int s, output int e);
        int nt;
        c = 0; s = 0; e = 0; nt = 0;
        for (int i = 0; i < len; i++) begin
            if (v[i]) nt++;
            else begin
                if (nt > c) begin s = i - nt; e = i - 1; c = nt; end
                nt = 0;
            end
        end
        if (nt > c) begin s = len - nt; e = len - 1; c = nt; end
    endfunction

    function automatic void model(input logic [31:0] p, input logic [31:0] m,
                                  input int n, output bit ok, output int tap);
        int c, s, e;
        logic [31:0] pp, mm;
        ok = 1'b0; tap = 0;
        if (n < 1 || n > 16) return;
        pp = p; mm = m;
        for (int i = 0; i < 2 * n; i++) begin
            if (!pp[i]) begin pp[i % n] = 1'b0; pp[i % n + n] = 1'b0; end
            if (!mm[i]) begin mm[i % n] = 1'b0; mm[i % n + n] = 1'b0; end
        end
        longest(pp, 2 * n, c, s, e);
        if (c == 2 * n) begin
            longest(mm, 2 * n, c, s, e);
            ok = (c != 0);
        end else begin
            ok = (c >= 3);
        end
        if (ok) tap = ((s + e) / 2) % n;
    endfunction

    task automatic run_case(input string req, input logic [31:0] p, input logic [31:0] m,
                            input int n, input bit exp_ok, input int exp_tap);
        int w;
        @(negedge clk);
        pass_map = p; match_map = m; tap_count = 8'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(drift_clr == 1'b1, {req, " R2 drift_clr pulse"}, drift_clr, 1);
        chk(drift_en == 1'b0, {req, " R2 drift_en cleared"}, drift_en, 0);
        w = 0;
        while (!done && w < 300) begin @(negedge clk); w++; end
        chk(w < 300, {req, " R11 done seen"}, w, 0);
        chk(fail == !exp_ok, {req, " fail flag"}, fail, !exp_ok);
        if (exp_ok) begin
            chk(tap_sel == 4'(exp_tap), {req, " R10 tap"}, tap_sel, exp_tap);
            chk(drift_en == 1'b1, {req, " R10 drift_en"}, drift_en, 1);
            last_tap = exp_tap;
        end else begin
            chk(drift_en == 1'b0, {req, " R9 drift_en"}, drift_en, 0);
            chk(tap_sel == 4'(last_tap), {req, " R9 tap held"}, tap_sel, last_tap);
        end
        @(negedge clk);
        chk(done == 1'b0, {req, " R11 done one cycle"}, done, 0);
        chk(drift_clr == 1'b0, {req, " R2 drift_clr one cycle"}, drift_clr, 0);
    endtask

    task automatic t_reset();
        chk(done == 0 && fail == 0 && drift_en == 0 && drift_clr == 0, "R1 flags", {done, fail, drift_en, drift_clr}, 0);
        chk(tap_sel == 0, "R1 tap_sel", tap_sel, 0);
    endtask

    task automatic t_merge_poison();
        // R3: entry 2 and entry 13 (tap 5) fail; longest run 6..9 -> tap 7
        run_case("R3 merge", ~32'h0000_2004, 32'hFFFF_FFFF, 8, 1'b1, 7);
    endtask

    task automatic t_tie();
        // R5: taps 0 and 4 fail; runs of 3 everywhere, earliest 1..3 -> tap 2
        run_case("R5 tie", ~32'h0000_1001, 32'hFFFF_FFFF, 8, 1'b1, 2);
    endtask

    task automatic t_short();
        // R7: alternating taps fail, longest run 1
        run_case("R7 short", 32'hFFFF_FFAA, 32'hFFFF_FFFF, 4, 1'b0, 0);
    endtask

    task automatic t_exact_three();
        // R7: N=4, tap 3 fails -> runs 0..2 and 4..6 of 3 -> tap 1
        run_case("R7 three", 32'h0000_0077, 32'h0000_00FF, 4, 1'b1, 1);
    endtask

    task automatic t_all_match();
        // R4 R6: all pass and all match, run ends at last entry: (0+15)/2 mod 8 = 7
        run_case("R4 R6 end run", 32'h0000_FFFF, 32'h0000_FFFF, 8, 1'b1, 7);
    endtask

    task automatic t_match_fallback();
        // R6 R8: all pass, tap 6 mismatches -> run 7..13 -> 10 mod 8 = 2
        run_case("R6 R8 fallback", 32'h0000_FFFF, ~32'h0000_4040, 8, 1'b1, 2);
    endtask

    task automatic t_no_match();
        // R6: all pass, nothing matches -> fail, tap held
        run_case("R6 R9 no match", 32'hFFFF_FFFF, 32'h0000_0000, 8, 1'b0, 0);
    endtask

    task automatic t_upper_ignored();
        // R3: bits at 2N and above ignored; N=4 lower 8 all set -> tap 3
        run_case("R3 upper bits", 32'h0000_00FF, 32'h5A00_00FF, 4, 1'b1, 3);
    endtask

    task automatic t_single_tap();
        // R8: N=1, both entries pass and match -> tap 0
        run_case("R8 one tap", 32'h0000_0003, 32'h0000_0003, 1, 1'b1, 0);
    endtask

    task automatic t_bad_counts();
        // R12
        run_case("R12 zero", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0, 0);
        run_case("R12 seventeen", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 17, 1'b0, 0);
    endtask

    task automatic t_busy_start();
        // R11: a second start while busy must not restart or add a drift_clr
        int w, extra;
        @(negedge clk);
        pass_map = ~32'h0000_2004; match_map = '1; tap_count = 8'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        tap_count = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0; extra = 0;
        while (!done && w < 300) begin
            if (drift_clr) extra++;
            @(negedge clk); w++;
        end
        chk(extra == 0, "R11 busy drift_clr", extra, 0);
        chk(fail == 1'b0, "R11 busy result fail", fail, 0);
        chk(tap_sel == 4'd7, "R11 busy result tap", tap_sel, 7);
        last_tap = 7;
        @(negedge clk);
    endtask

    task automatic t_random();
        // R8: assorted sweeps against the spec model
        for (int k = 0; k < 24; k++) begin
            logic [31:0] p, m;
            int n, tap;
            bit ok;
            n = 1 + ($urandom % 16);
            p = (k % 3 == 0) ? 32'hFFFF_FFFF : ($urandom | $urandom | $urandom);
            m = $urandom | $urandom;
            model(p, m, n, ok, tap);
            run_case("R8 sweep", p, m, n, ok, tap);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_poison();
        t_tie();
        t_short();
        t_exact_three();
        t_all_match();
        t_match_fallback();
        t_no_match();
        t_upper_ignored();
        t_single_tap();
        t_bad_counts();
        t_busy_start();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule